// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between a clocked host and an asynchronous static RAM with a 15-bit address and an 8-bit data bus. The host raises a request with a write flag, an address and, for writes, a byte of data. The controller turns each single-beat request into a RAM cycle with chip select, write enable and output enable, all active low. Each cycle lasts long enough to meet the RAM's timing minimums, and each minimum is given as a nanosecond parameter. A one-cycle done strobe tells the host when the access has finished. For reads, the captured byte waits in a host-side register.

The RAM data bus is bidirectional. The controller exposes it as a separate output byte, an input byte and a driver-enable line, so that a tristate pad at the chip boundary can join them. The controller keeps output enable high for the whole of every write. It turns its drivers on only while write enable is low. The address is loaded only when a request is accepted in idle, so it cannot move during a write overlap. Between accesses, chip select stays high and the RAM rests in low-power standby.

Each timing minimum becomes a cycle count: the ceiling of nanoseconds divided by the clock period. A nonzero value always gives at least one cycle.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, `ram_cs_n`, `ram_we_n` and `ram_oe_n` are 1, `ram_dq_oe` is 0 and `host_done` is 0.
- R2: A write request sampled high with `host_we`=1 in idle starts a write on that clock edge. Chip select and write enable are then low for exactly WP_CYC cycles. WP_CYC is the largest of the cycle counts for pulse width, address-to-end and data setup, which is 1 with a 10 ns clock. The byte is then stored at the requested address.
- R3: `ram_addr` takes the host address at the accepting edge. It holds that value until the next accepted request, and it never changes while chip select and write enable are both low.
- R4: `ram_oe_n` stays 1 during every cycle in which `ram_we_n` is 0.
- R5: `ram_dq_oe` is 1 only while `ram_we_n` is 0, and `ram_dq_out` then carries the write byte.
- R6: A read request (`host_we`=0) drives chip select and output enable low, with write enable high, for RD_CYC cycles. RD_CYC is the largest of the counts for cycle time, address access and select access, which is 2 with a 10 ns clock. `ram_dq_in` is captured into `host_rdata` at the edge that ends those cycles, and it holds there until the next read.
- R7: `host_done` is high for exactly one cycle. It rises on the edge that ends the RAM cycle, when chip select also returns high.
- R8: A request raised while an access or its done cycle is in progress is ignored. It starts no RAM cycle and changes neither the address nor the stored data.
- R9: The cycle count for a time of t ns is ceil(t / CLK_PERIOD_NS) for t > 0, and 0 for t = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Request, sampled in idle only |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 15 | Access address |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Last byte read |
| host_done | output | 1 | One-cycle completion strobe |
| ram_addr | output | 15 | RAM address |
| ram_dq_out | output | 8 | Data toward the RAM |
| ram_dq_in | input | 8 | Data from the RAM |
| ram_dq_oe | output | 1 | Enable for the data bus drivers |
| ram_cs_n | output | 1 | Chip select, active low |
| ram_we_n | output | 1 | Write enable, active low |
| ram_oe_n | output | 1 | Output enable, active low |

## Verification
With a 10 ns clock, let E0 be the edge that accepts a write. The write strobes are low in the cycle after E0, and they rise with `host_done` at E0+1; done falls at E0+2. For a read, select and output enable are low for two cycles. Data is captured and done rises at E0+2, and done falls at E0+3. The bench samples every output on the falling clock edge between those edges. The RAM model returns valid data only after two full cycles of stable selected read, so a read that is too short shows up as a wrong byte.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_FIN  = 2'd3
  } ctrl_state_e;

  // R9: ceiling of ns / period; zero stays zero, any nonzero time is >= 1
  function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                            input int unsigned period);
    if (ns == 0) return 0;
    return (ns + period - 1) / period;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remain_q <= '0;
    else if (load_i)           remain_q <= load_val_i - 1'b1;
    else if (remain_q != '0)   remain_q <= remain_q - 1'b1;
  end

  assign expire_o = (remain_q == '0);

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_load_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              drive_nxt_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] wbyte_q;
  logic [DATA_W-1:0] rbyte_q;
  logic              drive_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbyte_q <= '0;
      rbyte_q <= '0;
      drive_q <= 1'b0;
    end else begin
      drive_q <= drive_nxt_i;
      if (wr_load_i) wbyte_q <= wdata_i;
      if (cap_i)     rbyte_q <= dq_i;
    end
  end

  assign dq_o    = wbyte_q;
  assign dq_oe_o = drive_q;
  assign rdata_o = rbyte_q;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 12,
  parameter int T_AA_NS       = 12,
  parameter int T_ACS_NS      = 12,
  parameter int T_WP_NS       = 9,
  parameter int T_AW_NS       = 9,
  parameter int T_DW_NS       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_done,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_out,
  input  logic [DATA_W-1:0] ram_dq_in,
  output logic              ram_dq_oe,
  output logic              ram_cs_n,
  output logic              ram_we_n,
  output logic              ram_oe_n
);

  // R9: cycle counts derived from nanosecond minimums, never below one cycle
  localparam int RD_RAW = max3(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS),
                               ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                               ns_to_cyc(T_ACS_NS, CLK_PERIOD_NS));
  localparam int WP_RAW = max3(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                               ns_to_cyc(T_AW_NS, CLK_PERIOD_NS),
                               ns_to_cyc(T_DW_NS, CLK_PERIOD_NS));
  localparam int RD_CYC  = (RD_RAW < 1) ? 1 : RD_RAW;
  localparam int WP_CYC  = (WP_RAW < 1) ? 1 : WP_RAW;
  localparam int CNT_MAX = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  ctrl_state_e state_q, state_nxt;
  logic        accept;
  logic        tmr_expire;
  logic        rd_capture;
  logic [CNT_W-1:0] tmr_load_val;
  logic [ADDR_W-1:0] addr_q;
  logic        cs_n_q, we_n_q, oe_n_q;

  assign accept       = (state_q == ST_IDLE) && host_req;
  assign rd_capture   = (state_q == ST_RD) && tmr_expire;
  assign tmr_load_val = host_we ? CNT_W'(WP_CYC) : CNT_W'(RD_CYC);

  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_nxt = host_we ? ST_WR : ST_RD;
      ST_RD:   if (tmr_expire) state_nxt = ST_FIN;
      ST_WR:   if (tmr_expire) state_nxt = ST_FIN;
      ST_FIN:  state_nxt = ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  // RAM strobes are registered from the next state so they never glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      cs_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
    end else begin
      state_q <= state_nxt;
      if (accept) addr_q <= host_addr;
      cs_n_q <= !((state_nxt == ST_RD) || (state_nxt == ST_WR));
      we_n_q <= !(state_nxt == ST_WR);
      oe_n_q <= !(state_nxt == ST_RD);
    end
  end

  sram_cycle_timer #(.CNT_W(CNT_W)) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept),
    .load_val_i (tmr_load_val),
    .expire_o   (tmr_expire)
  );

  sram_dq_path #(.DATA_W(DATA_W)) dq_path_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_load_i   (accept && host_we),
    .wdata_i     (host_wdata),
    .drive_nxt_i (state_nxt == ST_WR),
    .cap_i       (rd_capture),
    .dq_i        (ram_dq_in),
    .dq_o        (ram_dq_out),
    .dq_oe_o     (ram_dq_oe),
    .rdata_o     (host_rdata)
  );

  assign ram_addr  = addr_q;
  assign ram_cs_n  = cs_n_q;
  assign ram_we_n  = we_n_q;
  assign ram_oe_n  = oe_n_q;
  assign host_done = (state_q == ST_FIN);

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_cs_n && !ram_we_n && $past(!ram_cs_n && !ram_we_n)) |-> $stable(ram_addr)); // R3
  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> ram_oe_n); // R4
  AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> !ram_we_n); // R5
  AST_PULSE_ENDS_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> $past(tmr_expire)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done); // R7
  AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |-> (ram_cs_n && ram_we_n && ram_oe_n)); // R1
  AST_CAPTURE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |-> (!ram_cs_n && !ram_oe_n)); // R6

endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb_top;

  localparam int CLK_NS  = 10;
  localparam int WD_MAX  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [14:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_done;
  logic [14:0] ram_addr;
  logic [7:0]  ram_dq_out;
  logic [7:0]  ram_dq_in;
  logic        ram_dq_oe;
  logic        ram_cs_n, ram_we_n, ram_oe_n;

  int n_chk = 0;
  int n_bad = 0;
  int wd_cnt = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_async_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_done(host_done), .ram_addr(ram_addr), .ram_dq_out(ram_dq_out),
    .ram_dq_in(ram_dq_in), .ram_dq_oe(ram_dq_oe), .ram_cs_n(ram_cs_n),
    .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n)
  );

  // RAM model: 64 bytes indexed by the low address bits; read data only
  // valid after two full cycles of stable selected read (12 ns at 10 ns).
  logic [7:0]  mem [64];
  int          rd_age = 0;
  logic [14:0] rd_addr_prev = '0;
  logic [14:0] ov_addr_prev = '0;
  logic        ov_prev = 1'b0;
  int          viol_addr = 0, viol_oe = 0, viol_drv = 0;

  assign ram_dq_in = (rd_age >= 2) ? mem[ram_addr[5:0]] : 8'hEE;

  always @(negedge clk) begin
    if (!ram_cs_n && !ram_we_n) mem[ram_addr[5:0]] <= ram_dq_out;
    if (!ram_cs_n && !ram_oe_n && ram_we_n && (rd_age == 0 || ram_addr == rd_addr_prev))
      rd_age <= rd_age + 1;
    else if (!ram_cs_n && !ram_oe_n && ram_we_n)
      rd_age <= 1;
    else
      rd_age <= 0;
    rd_addr_prev <= ram_addr;
    if (!ram_cs_n && !ram_we_n && ov_prev && ram_addr != ov_addr_prev) viol_addr++;
    if (!ram_we_n && !ram_oe_n) viol_oe++;
    if (ram_dq_oe && ram_we_n) viol_drv++;
    ov_prev      <= !ram_cs_n && !ram_we_n;
    ov_addr_prev <= ram_addr;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(ram_cs_n && ram_we_n && ram_oe_n && !ram_dq_oe && !host_done, tag,
        {ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe, host_done}, 5'b11100);
  endtask

  // R2 R5 R7: write timeline, accept edge E0
  task automatic do_write(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk); host_req = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_req = 0; host_addr = ~a; host_wdata = ~d;
    chk(!ram_cs_n && !ram_we_n && ram_oe_n, "R2 strobes in pulse",
        {ram_cs_n, ram_we_n, ram_oe_n}, 3'b001);
    chk(ram_dq_oe && ram_dq_out == d, "R5 drive data", {ram_dq_oe, ram_dq_out}, {1'b1, d});
    chk(ram_addr == a, "R3 address", ram_addr, a);
    chk(!host_done, "R7 no early done", host_done, 0);
    @(negedge clk);
    chk(host_done && ram_cs_n && ram_we_n && !ram_dq_oe, "R2 R7 write end",
        {host_done, ram_cs_n, ram_we_n, ram_dq_oe}, 4'b1110);
    @(negedge clk);
    chk_idle("R1 R7 idle after write");
  endtask

  // R6 R7: read timeline
  task automatic do_read(input logic [14:0] a, input logic [7:0] exp);
    @(negedge clk); host_req = 1; host_we = 0; host_addr = a;
    @(negedge clk); host_req = 0; host_addr = ~a;
    chk(!ram_cs_n && !ram_oe_n && ram_we_n && !ram_dq_oe, "R6 read strobes c1",
        {ram_cs_n, ram_oe_n, ram_we_n, ram_dq_oe}, 4'b0010);
    chk(ram_addr == a, "R3 read address", ram_addr, a);
    @(negedge clk);
    chk(!ram_cs_n && !ram_oe_n && !host_done, "R6 read strobes c2",
        {ram_cs_n, ram_oe_n, host_done}, 3'b000);
    @(negedge clk);
    chk(host_done && ram_cs_n && ram_oe_n, "R6 R7 read end",
        {host_done, ram_cs_n, ram_oe_n}, 3'b111);
    chk(host_rdata == exp, "R6 read data", host_rdata, exp);
    @(negedge clk);
    chk_idle("R1 R7 idle after read");
    chk(host_rdata == exp, "R6 read data held", host_rdata, exp);
  endtask

  // R8: requests during a busy write and a busy read are ignored
  task automatic busy_ignore();
    @(negedge clk); host_req = 1; host_we = 1; host_addr = 15'h0022; host_wdata = 8'h5A;
    @(negedge clk); host_we = 0; host_addr = 15'h0015; host_wdata = 8'h11;
    @(negedge clk);
    chk(host_done, "R8 write done", host_done, 1);
    host_req = 0;
    @(negedge clk);
    chk_idle("R8 busy request not taken");
    chk(ram_addr == 15'h0022, "R8 address kept", ram_addr, 15'h0022);
    @(negedge clk); host_req = 1; host_we = 0; host_addr = 15'h0022;
    @(negedge clk); host_we = 1; host_addr = 15'h0015; host_wdata = 8'h77;
    @(negedge clk);
    @(negedge clk);
    chk(host_done && host_rdata == 8'h5A, "R8 read done", host_rdata, 8'h5A);
    host_req = 0;
    @(negedge clk);
    chk_idle("R8 busy write not taken");
    chk(ram_addr == 15'h0022, "R8 address kept after read", ram_addr, 15'h0022);
    do_read(15'h0015, 8'hFF);
  endtask

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > WD_MAX) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", wd_cnt, WD_MAX);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk_idle("R1 reset state");
    rst_n = 1;
    @(negedge clk);
    chk_idle("R1 idle after reset");
    do_write(15'h0003, 8'hA5);
    do_write(15'h7FC1, 8'h3C);
    do_write(15'h0015, 8'hFF);
    do_write(15'h4000, 8'h00);
    do_write(15'h7FFF, 8'h81);
    do_read(15'h0003, 8'hA5);
    do_read(15'h7FC1, 8'h3C);
    do_read(15'h7FFF, 8'h81);
    do_read(15'h4000, 8'h00);
    do_write(15'h0003, 8'h96);
    do_read(15'h0003, 8'h96);
    busy_ignore();
    repeat (4) @(negedge clk);
    chk_idle("R1 long idle standby");
    chk(viol_addr == 0, "R3 address moved in overlap", viol_addr, 0);
    chk(viol_oe == 0, "R4 output enable low in write", viol_oe, 0);
    chk(viol_drv == 0, "R5 drivers on outside pulse", viol_drv, 0);
    // R9: 12 ns -> 2 cycles, 9 ns -> 1 cycle at 10 ns, timed in the tasks above
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule